// File: doc/BRIEF.md
# Fully Associative Superpage Translation Buffer

This block translates 43-bit virtual addresses into 34-bit physical addresses through a 32-entry, fully associative array of cached translations. A lookup presents an address together with an access type (read or write) and a privilege mode (user or kernel). In the same cycle the block reports one of three outcomes: a hit with the physical address, a miss, or a protection fault. The base page is 8 KB. Each entry carries its own page-size code, so one entry can map a single base page or an aligned run of 8, 64 or 512 base pages.

A separate fill port writes one translation into the array. It uses the lowest free entry while one exists. Once the array is full it picks a pseudo-random entry, but never the one that produced the latest translated hit. A flush input invalidates every entry at once. Addresses whose two top bits select the direct window bypass the array completely and are treated as physical addresses, which is legal only in kernel mode. The page-table walker that produces fills sits outside this block.

Top module: `tlb_fa_super`

## Requirements
- R1: On a translated hit, `rs_pa` is the entry's frame number concatenated with `lk_va[12:0]`, which passes through untranslated.
- R2: `fill_size` code s (0, 1, 2, 3) makes an entry cover 1, 8, 64 or 512 base pages. The low 3*s bits of the virtual page number (`lk_va[42:13]`) are left out of the tag compare and replace the low 3*s bits of the stored frame number in `rs_pa`. A page number just outside that aligned run misses.
- R3: Results are combinational in the cycle of the lookup. While `lk_valid` is high, exactly one of `rs_hit`, `rs_miss` and `rs_fault` is high. While it is low, all result outputs, including `rs_pa`, are zero.
- R4: The 4-bit `fill_perm` holds kernel-read in bit 0, kernel-write in bit 1, user-read in bit 2 and user-write in bit 3. A matching lookup whose mode and access type have their bit clear raises `rs_fault` with `rs_hit` low.
- R5: A lookup outside the direct window that matches no valid entry raises `rs_miss` with `rs_hit` low.
- R6: When more than one valid entry matches, the entry with the lowest index supplies the translation.
- R7: When `lk_va[63:62]` is 2'b10, `rs_bypass` is high and the array is not consulted. In kernel mode `rs_hit` is high and `rs_pa` equals `lk_va[33:0]`. In user mode `rs_fault` is high. Other values of the top two bits are translated normally.
- R8: A cycle with `flush_all` high leaves every entry invalid from the next cycle on. It takes priority over a fill in the same cycle.
- R9: While any entry is invalid, a fill writes the lowest-indexed invalid entry, so after a flush 32 fills of distinct pages are all retained.
- R10: With every entry valid, a fill replaces exactly one entry, and never the entry that gave the most recent translated hit.
- R11: After reset every entry is invalid, so every translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_kernel | input | 1 | Privilege mode: 1 kernel, 0 user |
| fill_en | input | 1 | Write one translation this cycle |
| fill_vpn | input | 30 | Virtual page number of the new translation |
| fill_pfn | input | 21 | Physical frame number of the new translation |
| fill_size | input | 2 | Page-size code (0..3: 1, 8, 64, 512 pages) |
| fill_perm | input | 4 | Permission bits (see R4) |
| flush_all | input | 1 | Invalidate every entry |
| rs_hit | output | 1 | Translation or direct access granted |
| rs_miss | output | 1 | No matching valid entry |
| rs_fault | output | 1 | Protection fault |
| rs_bypass | output | 1 | Address lies in the direct window |
| rs_pa | output | 34 | Physical address, valid with rs_hit |

## Verification
The assertions assume that inputs are known (never X) out of reset. They also assume the lookup fields are stable over each cycle, so the combinational results can be judged at the edge. The flush property depends on nothing outside the block, because the flush overrides any fill in the same cycle. The bench drives every input on the falling edge and keeps lookups and fills in separate cycles, except for one deliberate cycle that presents a flush and a fill together. It uses only the four defined size codes and sweeps all 16 permission patterns.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned DEF_ENTRIES  = 32;
    localparam int unsigned DEF_ADDR_W   = 64;
    localparam int unsigned DEF_VA_BITS  = 43;
    localparam int unsigned DEF_PA_BITS  = 34;
    localparam int unsigned DEF_OFF_BITS = 13;
    localparam int unsigned DEF_SP_STEP  = 3;
    localparam int unsigned DEF_LFSR_W   = 8;
    localparam int unsigned PERM_W       = 4;
    localparam int unsigned SZ_W         = 2;

    // Top address bits that select the untranslated kernel window.
    localparam logic [1:0] DIRECT_WIN_TAG = 2'b10;

    // Permission slot: {user, write}; bit0 k-read, bit1 k-write, bit2 u-read, bit3 u-write.
    function automatic logic [1:0] perm_slot(input logic kernel, input logic write);
        return {~kernel, write};
    endfunction
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp #(
    parameter int VPN_W   = 30,
    parameter int PFN_W   = 21,
    parameter int SP_STEP = 3,
    parameter int SZ_W    = 2
) (
    input  logic             valid_i,
    input  logic [VPN_W-1:0] tag_i,
    input  logic [VPN_W-1:0] req_i,
    input  logic [PFN_W-1:0] pfn_i,
    input  logic [SZ_W-1:0]  size_i,
    output logic             match_o,
    output logic [PFN_W-1:0] frame_o
);
    logic [VPN_W-1:0] vmask;
    logic [PFN_W-1:0] pmask;

    always_comb begin
        for (int b = 0; b < VPN_W; b++) vmask[b] = (b < SP_STEP * int'(size_i));
        for (int b = 0; b < PFN_W; b++) pmask[b] = (b < SP_STEP * int'(size_i));
        match_o = valid_i && (((tag_i ^ req_i) & ~vmask) == '0);
        frame_o = (pfn_i & ~pmask) | (req_i[PFN_W-1:0] & pmask);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N      = 32,
    parameter int IDX_W  = $clog2(N),
    parameter int LFSR_W = 8
) (
    input  logic [N-1:0]      vld_i,
    input  logic [LFSR_W-1:0] rnd_i,
    input  logic [IDX_W-1:0]  last_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] alt_idx;

    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_free (
        .vec_i (~vld_i),
        .any_o (free_any),
        .idx_o (free_idx)
    );

    always_comb begin
        rnd_idx = IDX_W'(int'(rnd_i) % N);
        alt_idx = rnd_idx;
        if (rnd_idx == last_i) begin
            alt_idx = (rnd_idx == IDX_W'(N - 1)) ? '0 : rnd_idx + 1'b1;
        end
        idx_o = free_any ? free_idx : alt_idx;
    end
endmodule

// File: rtl/tlb_fa_super.sv
module tlb_fa_super
    import tlb_pkg::*;
#(
    parameter int          ENTRIES   = DEF_ENTRIES,
    parameter int          ADDR_W    = DEF_ADDR_W,
    parameter int          VA_BITS   = DEF_VA_BITS,
    parameter int          PA_BITS   = DEF_PA_BITS,
    parameter int          OFF_BITS  = DEF_OFF_BITS,
    parameter int          SP_STEP   = DEF_SP_STEP,
    parameter int          LFSR_W    = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
    localparam int VPN_W = VA_BITS - OFF_BITS,
    localparam int PFN_W = PA_BITS - OFF_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_va,
    input  logic               lk_write,
    input  logic               lk_kernel,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic [SZ_W-1:0]    fill_size,
    input  logic [PERM_W-1:0]  fill_perm,
    input  logic               flush_all,
    output logic               rs_hit,
    output logic               rs_miss,
    output logic               rs_fault,
    output logic               rs_bypass,
    output logic [PA_BITS-1:0] rs_pa
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][SZ_W-1:0]   size;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]               last_hit;
        logic [LFSR_W-1:0]              lfsr;
    } tlb_state_t;

    tlb_state_t st_q, st_d;

    logic [VPN_W-1:0]              req_vpn;
    logic                          dir_win;
    logic [ENTRIES-1:0]            match_vec;
    logic [ENTRIES-1:0][PFN_W-1:0] frame_arr;
    logic                          any_match;
    logic [IDX_W-1:0]              hit_idx;
    logic [IDX_W-1:0]              victim_idx;
    logic [PERM_W-1:0]             perm_sel;
    logic                          allow;
    logic                          tr_hit;
    logic                          unused_va_mid;

    assign req_vpn       = lk_va[VA_BITS-1:OFF_BITS];
    assign dir_win       = (lk_va[ADDR_W-1:ADDR_W-2] == DIRECT_WIN_TAG);
    assign unused_va_mid = ^lk_va[ADDR_W-3:VA_BITS];

    // One comparator per entry, each applying its own size mask.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        tlb_entry_cmp #(
            .VPN_W   (VPN_W),
            .PFN_W   (PFN_W),
            .SP_STEP (SP_STEP),
            .SZ_W    (SZ_W)
        ) u_cmp (
            .valid_i (st_q.vld[e]),
            .tag_i   (st_q.tag[e]),
            .req_i   (req_vpn),
            .pfn_i   (st_q.pfn[e]),
            .size_i  (st_q.size[e]),
            .match_o (match_vec[e]),
            .frame_o (frame_arr[e])
        );
    end

    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_hitsel (
        .vec_i (match_vec),
        .any_o (any_match),
        .idx_o (hit_idx)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W), .LFSR_W(LFSR_W)) u_victim (
        .vld_i  (st_q.vld),
        .rnd_i  (st_q.lfsr),
        .last_i (st_q.last_hit),
        .idx_o  (victim_idx)
    );

    // Lookup result, same cycle.
    always_comb begin
        rs_hit    = 1'b0;
        rs_miss   = 1'b0;
        rs_fault  = 1'b0;
        rs_bypass = 1'b0;
        rs_pa     = '0;
        tr_hit    = 1'b0;
        perm_sel  = st_q.perm[hit_idx];
        allow     = perm_sel[perm_slot(lk_kernel, lk_write)];
        if (lk_valid) begin
            if (dir_win) begin
                rs_bypass = 1'b1;
                if (lk_kernel) begin
                    rs_hit = 1'b1;
                    rs_pa  = lk_va[PA_BITS-1:0];
                end else begin
                    rs_fault = 1'b1;
                end
            end else if (any_match) begin
                if (allow) begin
                    rs_hit = 1'b1;
                    tr_hit = 1'b1;
                    rs_pa  = {frame_arr[hit_idx], lk_va[OFF_BITS-1:0]};
                end else begin
                    rs_fault = 1'b1;
                end
            end else begin
                rs_miss = 1'b1;
            end
        end
    end

    // Next state.
    always_comb begin
        st_d      = st_q;
        st_d.lfsr = {1'b0, st_q.lfsr[LFSR_W-1:1]} ^ (st_q.lfsr[0] ? LFSR_TAPS : '0);
        if (tr_hit) st_d.last_hit = hit_idx;
        if (flush_all) begin
            st_d.vld = '0;
        end else if (fill_en) begin
            st_d.vld[victim_idx]  = 1'b1;
            st_d.tag[victim_idx]  = fill_vpn;
            st_d.pfn[victim_idx]  = fill_pfn;
            st_d.size[victim_idx] = fill_size;
            st_d.perm[victim_idx] = fill_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tlb_fa_super_chk.sv
module tlb_fa_super_chk #(
    parameter int PA_BITS  = 34,
    parameter int OFF_BITS = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_kernel,
    input logic [1:0]         va_top,
    input logic [PA_BITS-1:0] va_low,
    input logic               flush_all,
    input logic               rs_hit,
    input logic               rs_miss,
    input logic               rs_fault,
    input logic               rs_bypass,
    input logic [PA_BITS-1:0] rs_pa
);
    logic in_win;
    assign in_win = (va_top == 2'b10);

    // R3: one outcome per lookup
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));

    // R3: quiet while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!rs_hit && !rs_miss && !rs_fault && !rs_bypass && rs_pa == '0));

    // R1: offset passes through
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_hit && !rs_bypass) |-> (rs_pa[OFF_BITS-1:0] == va_low[OFF_BITS-1:0]));

    // R7: window in user mode faults
    p_win_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && in_win && !lk_kernel) |-> (rs_fault && rs_bypass));

    // R7: window in kernel mode is identity
    p_win_kernel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && in_win && lk_kernel) |-> (rs_hit && rs_pa == va_low));

    // R7: bypass only inside window
    p_bypass_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rs_bypass |-> in_win);

    // R8: nothing translates right after a flush
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !(rs_hit && !rs_bypass));
endmodule

bind tlb_fa_super tlb_fa_super_chk #(
    .PA_BITS  (PA_BITS),
    .OFF_BITS (OFF_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_kernel (lk_kernel),
    .va_top    (lk_va[ADDR_W-1:ADDR_W-2]),
    .va_low    (lk_va[PA_BITS-1:0]),
    .flush_all (flush_all),
    .rs_hit    (rs_hit),
    .rs_miss   (rs_miss),
    .rs_fault  (rs_fault),
    .rs_bypass (rs_bypass),
    .rs_pa     (rs_pa)
);

// File: tb/sim_tlb_fa_super.sv
module sim_tlb_fa_super;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_kernel;
    logic [63:0] lk_va;
    logic        fill_en, flush_all;
    logic [29:0] fill_vpn;
    logic [20:0] fill_pfn;
    logic [1:0]  fill_size;
    logic [3:0]  fill_perm;
    logic        rs_hit, rs_miss, rs_fault, rs_bypass;
    logic [33:0] rs_pa;

    logic        c_hit, c_miss, c_fault, c_byp;
    logic [33:0] c_pa;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_fa_super u0 (
        .clk, .rst_n, .lk_valid, .lk_va, .lk_write, .lk_kernel,
        .fill_en, .fill_vpn, .fill_pfn, .fill_size, .fill_perm, .flush_all,
        .rs_hit, .rs_miss, .rs_fault, .rs_bypass, .rs_pa
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkva(input logic [29:0] vpn, input logic [12:0] off);
        return {21'd0, vpn, off};
    endfunction

    function automatic logic [33:0] exp_pa(input logic [20:0] pfn, input int s,
                                           input logic [29:0] vpn, input logic [12:0] off);
        logic [20:0] m;
        m = (21'd1 << (3 * s)) - 21'd1;
        return {(pfn & ~m) | (vpn[20:0] & m), off};
    endfunction

    function automatic logic [20:0] pf_of(input logic [29:0] v);
        return v[20:0] ^ 21'h1F0F0;
    endfunction

    task automatic look(input logic [63:0] va, input logic w, input logic k);
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0;
        lk_valid = 1'b1; lk_va = va; lk_write = w; lk_kernel = k;
        #1;
        c_hit = rs_hit; c_miss = rs_miss; c_fault = rs_fault; c_byp = rs_bypass; c_pa = rs_pa;
    endtask

    task automatic fill(input logic [29:0] v, input logic [20:0] p, input logic [1:0] s,
                        input logic [3:0] pm);
        @(negedge clk);
        lk_valid = 1'b0; flush_all = 1'b0;
        fill_en = 1'b1; fill_vpn = v; fill_pfn = p; fill_size = s; fill_perm = pm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush(input logic with_fill, input logic [29:0] v);
        @(negedge clk);
        lk_valid = 1'b0; flush_all = 1'b1;
        fill_en = with_fill; fill_vpn = v; fill_pfn = pf_of(v); fill_size = 2'd0; fill_perm = 4'hF;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
    endtask

    logic [29:0] resident [32];

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_write = 1'b0; lk_kernel = 1'b0;
        fill_en = 1'b0; flush_all = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_size = '0; fill_perm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3: idle outputs quiet
        chk("R3 idle outputs", {rs_hit, rs_miss, rs_fault, rs_bypass, rs_pa}, '0);

        // R11: empty after reset
        for (int i = 0; i < 4; i++) begin
            look(mkva(30'(i * 777 + 3), 13'h55), 1'b0, 1'b1);
            chk("R11 miss after reset", c_miss, 1);
            chk("R11 no hit after reset", c_hit, 0);
        end

        // R1/R2: size sweep
        for (int s = 0; s < 4; s++) begin
            logic [29:0] v, m, base;
            logic [20:0] p;
            logic [29:0] ins [4];
            v = 30'h2ABC_DEF5; p = 21'h15A5A3;
            m = (30'd1 << (3 * s)) - 30'd1;
            base = v & ~m;
            flush(1'b0, '0);
            fill(v, p, 2'(s), 4'hF);
            ins[0] = base; ins[1] = base | m; ins[2] = base | (m >> 1);
            ins[3] = base | (30'($urandom) & m);
            for (int j = 0; j < 4; j++) begin
                logic [12:0] off;
                off = 13'($urandom);
                look(mkva(ins[j], off), 1'b0, 1'b1);
                chk("R2 in-region hit", c_hit, 1);
                chk("R1 R2 translated address", c_pa, exp_pa(p, s, ins[j], off));
                chk("R3 single outcome", 64'(c_hit + c_miss + c_fault), 1);
            end
            look(mkva(base + m + 30'd1, 13'h0), 1'b0, 1'b1);
            chk("R2 above region misses", c_miss, 1);
            look(mkva(base - 30'd1, 13'h1FFF), 1'b0, 1'b1);
            chk("R2 below region misses", c_miss, 1);
        end

        // R4: permission sweep
        for (int p = 0; p < 16; p++) begin
            flush(1'b0, '0);
            fill(30'h155, 21'h0AB, 2'd0, 4'(p));
            for (int k = 0; k < 2; k++) begin
                for (int w = 0; w < 2; w++) begin
                    logic ok;
                    ok = p[(k != 0 ? 0 : 2) + w];
                    look(mkva(30'h155, 13'h10), 1'(w), 1'(k));
                    chk("R4 hit when enabled", c_hit, ok);
                    chk("R4 fault when disabled", c_fault, !ok);
                end
            end
        end

        // R5: miss on a different page
        look(mkva(30'h156, 13'h10), 1'b0, 1'b1);
        chk("R5 miss", c_miss, 1);
        chk("R5 no hit", c_hit, 0);

        // R6: lowest index wins
        flush(1'b0, '0);
        fill(30'h3000, 21'h00111, 2'd0, 4'hF);
        fill(30'h3000, 21'h00222, 2'd0, 4'hF);
        fill(30'h3000, 21'h00333, 2'd3, 4'hF);
        look(mkva(30'h3000, 13'h7), 1'b1, 1'b0);
        chk("R6 lowest entry wins", c_pa, {21'h00111, 13'h7});
        flush(1'b0, '0);
        fill(30'h3005, 21'h00E00, 2'd3, 4'hF);
        fill(30'h3005, 21'h00444, 2'd0, 4'hF);
        look(mkva(30'h3005, 13'h9), 1'b0, 1'b0);
        chk("R6 superpage in lower entry wins", c_pa, {21'h00E05, 13'h9});

        // R7: direct window
        look({2'b10, 28'h0ABCDEF, 34'h1_2345_6789}, 1'b0, 1'b1);
        chk("R7 kernel window hit", {c_hit, c_byp}, 2'b11);
        chk("R7 kernel window identity", c_pa, 34'h1_2345_6789);
        look({2'b10, 28'h0, 34'h0_0000_1000}, 1'b1, 1'b1);
        chk("R7 kernel window write", c_pa, 34'h0_0000_1000);
        look({2'b10, 28'h0ABCDEF, 34'h1_2345_6789}, 1'b0, 1'b0);
        chk("R7 user window fault", {c_fault, c_hit, c_byp}, 3'b101);
        look({2'b11, 19'h0, 30'h3005, 13'h2}, 1'b0, 1'b1);
        chk("R7 top 11 translated", {c_hit, c_byp}, 2'b10);
        chk("R7 top 11 address", c_pa, {21'h00E05, 13'h2});
        look({2'b01, 19'h0, 30'h7777, 13'h2}, 1'b0, 1'b1);
        chk("R7 top 01 unmapped misses", {c_miss, c_byp}, 2'b10);

        // R8: flush
        flush(1'b0, '0);
        fill(30'h0BEEF, pf_of(30'h0BEEF), 2'd0, 4'hF);
        look(mkva(30'h0BEEF, 13'h0), 1'b0, 1'b1);
        chk("R8 present before flush", c_hit, 1);
        flush(1'b0, '0);
        look(mkva(30'h0BEEF, 13'h0), 1'b0, 1'b1);
        chk("R8 gone after flush", c_miss, 1);
        fill(30'h0BEEF, pf_of(30'h0BEEF), 2'd0, 4'hF);
        flush(1'b1, 30'h0CAFE);
        look(mkva(30'h0CAFE, 13'h0), 1'b0, 1'b1);
        chk("R8 flush beats same-cycle fill", c_miss, 1);
        look(mkva(30'h0BEEF, 13'h0), 1'b0, 1'b1);
        chk("R8 older entry flushed", c_miss, 1);

        // R9: free entries used first
        flush(1'b0, '0);
        for (int i = 0; i < 32; i++) begin
            resident[i] = 30'(1000 + i * 3);
            fill(resident[i], pf_of(resident[i]), 2'd0, 4'hF);
        end
        for (int i = 0; i < 32; i++) begin
            look(mkva(resident[i], 13'h4), 1'b0, 1'b1);
            chk("R9 all fills retained", c_pa, {pf_of(resident[i]), 13'h4});
        end

        // R10: replacement when full
        for (int r = 0; r < 150; r++) begin
            int j, miss_cnt, miss_at;
            logic [29:0] nv;
            j = int'($urandom % 32);
            nv = 30'(200000 + r * 5);
            look(mkva(resident[j], 13'h0), 1'b0, 1'b0);
            chk("R10 protected entry hits before fill", c_hit, 1);
            fill(nv, pf_of(nv), 2'd0, 4'hF);
            look(mkva(resident[j], 13'h0), 1'b0, 1'b1);
            chk("R10 last hit entry kept", c_hit, 1);
            look(mkva(nv, 13'h1), 1'b1, 1'b1);
            chk("R10 new entry present", c_pa, {pf_of(nv), 13'h1});
            miss_cnt = 0; miss_at = 0;
            for (int i = 0; i < 32; i++) begin
                if (i != j) begin
                    look(mkva(resident[i], 13'h0), 1'b0, 1'b1);
                    if (c_miss) begin
                        miss_cnt++;
                        miss_at = i;
                    end
                end
            end
            chk("R10 exactly one entry evicted", 64'(miss_cnt), 1);
            if (miss_cnt == 1) resident[miss_at] = nv;
            else r = 1000;
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule